// File: doc/BRIEF.md
# Write Leveling Sequencer

This block drives the controller side of the write leveling procedure for one byte lane of a DDR3-style memory. When `start` is seen in idle, it issues a mode register load that turns leveling on. It then holds the command bus at NOP for the rest of the run, raises ODT after the mode-load settling time, and enables the strobe after the strobe-enable wait. From that point it sends single strobe pulses. Each pulse uses the current delay tap. The tap begins at 0 and rises by one after every pulse that does not lock.

After each rising strobe edge the block waits the feedback latency and then samples the prime data line, bit 0 of `dq_in`. The tap locks on the first pulse whose sample is 1 when an earlier pulse has already returned 0. If the top tap is used up without such a change, the run ends with an error. The other data bits must stay low while a run is active, and a high level on any of them sets the error flag. To leave, the block drops ODT, sends a mode register load with leveling off, and pulses `done`. The analog delay line is driven from `tap_o`.

Top module: `wrlvl_seq`

## Requirements
- R1: A `start` seen in idle gives, in the next cycle, `cmd_o` = 2'b01 (mode register load) with `mr_wl_o` = 1. A `start` while a run is active has no effect on the run or its timing.
- R2: The command codes are 2'b00 (NOP or deselect) and 2'b01 (mode register load). A run issues exactly two loads, the entry load and the exit load. Every other cycle of the run carries 2'b00.
- R3: `odt_o` first goes high after exactly T_MOD NOP cycles following the entry load. With the defaults it first goes high 13 cycles after the load cycle.
- R4: The first strobe rising edge comes EN_WAIT cycles after ODT rises. EN_WAIT = max(T_WLDQSEN, T_WLMRD - T_MOD - 1 - P), with P = max(T_WLO, T_DQSH + T_DQSL). This also places the first feedback sample at least T_WLMRD cycles after the entry load.
- R5: Each strobe pulse is high for T_DQSH cycles and then low. Feedback is sampled P cycles after the rising edge, and a new pulse starts every P + 1 cycles. `dqs_o` is only high while `dqs_oe_o` and `odt_o` are both high.
- R6: Feedback comes only from `dq_in[0]`. `tap_o` is 0 for the first pulse and goes up by one for each following pulse.
- R7: When a sample reads 1 and an earlier sample in the same run read 0, the tap locks. `tap_o` then keeps that pulse's tap after `done`, and `err_o` stays 0 unless R9 applies.
- R8: If the sample at the top tap (63) does not lock, the run ends with `err_o` = 1 and `tap_o` = 63. This includes runs whose first sample already reads 1.
- R9: A high level on any of `dq_in[DQ_W-1:1]` during an active run sets `err_o`. The run still completes and locks normally.
- R10: The exit follows the deciding sample: one cycle with ODT low and NOP, then a load with `mr_wl_o` = 0, then `done_o` high for exactly one cycle. `err_o` clears at the next start.
- R11: After reset, `cmd_o` = 2'b00 and `odt_o`, `dqs_oe_o`, `dqs_o`, `done_o` and `err_o` are 0, with `tap_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a leveling run (used only in idle) |
| dq_in | input | DQ_W | Lane data input; bit 0 carries feedback |
| cmd_o | output | 2 | Command code: 00 NOP/deselect, 01 mode register load |
| mr_wl_o | output | 1 | Leveling-enable bit sent with the load |
| odt_o | output | 1 | On-die termination enable |
| dqs_oe_o | output | 1 | Strobe output enable |
| dqs_o | output | 1 | Strobe level (true leg) |
| tap_o | output | TAP_W | Strobe delay tap |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No lock found, or a non-prime bit was high |

## Verification
The hardest case to reach is the lock decision, because it depends on the order of feedback values across pulses as well as on the value of a single sample. The bench models the memory as a step function of `tap_o` with a threshold taken from a vector table. Thresholds of 0 (feedback high from the first pulse, so no lock), 63 (lock exactly at the top tap) and 64 (never high) exercise the ordering rule and the edge of the tap range. A separate run injects a single-cycle high on a non-prime bit and a stray `start` partway through. It checks that the run still locks at the expected tap and in the expected cycle, and that the flag is raised.

// File: rtl/wrlvl_pkg.sv
package wrlvl_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_MRS = 2'b01
    } wl_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MRS_ON,
        ST_MOD,
        ST_ODT,
        ST_HI,
        ST_LO,
        ST_FBW,
        ST_SMP,
        ST_ODT_OFF,
        ST_MRS_OFF,
        ST_DONE
    } wl_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wrlvl_dq_split.sv
// Separates the prime feedback bit from the remaining lane bits and
// reduces the remaining bits to one "something is high" flag.
module wrlvl_dq_split #(
    parameter int DQ_W = 4
) (
    input  logic [DQ_W-1:0] dq_i,
    output logic            fb_o,
    output logic            stray_o
);
    logic [DQ_W-1:0] acc;

    assign acc[0] = 1'b0;
    for (genvar i = 1; i < DQ_W; i++) begin : g_or
        assign acc[i] = acc[i-1] | dq_i[i];
    end

    assign fb_o    = dq_i[0];
    assign stray_o = acc[DQ_W-1];
endmodule

// File: rtl/wrlvl_seq.sv
module wrlvl_seq
    import wrlvl_pkg::*;
#(
    parameter int DQ_W      = 4,
    parameter int TAP_W     = 6,
    parameter int T_MOD     = 12,
    parameter int T_WLDQSEN = 25,
    parameter int T_WLMRD   = 40,
    parameter int T_WLO     = 9,
    parameter int T_DQSH    = 1,
    parameter int T_DQSL    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DQ_W-1:0]  dq_in,
    output logic [1:0]       cmd_o,
    output logic             mr_wl_o,
    output logic             odt_o,
    output logic             dqs_oe_o,
    output logic             dqs_o,
    output logic [TAP_W-1:0] tap_o,
    output logic             done_o,
    output logic             err_o
);
    localparam int PULSE_HL = T_DQSH + T_DQSL;
    localparam int FB_WAIT  = imax(T_WLO - PULSE_HL, 0);
    localparam int SMP_LAT  = PULSE_HL + FB_WAIT;
    localparam int EN_WAIT  = imax(T_WLDQSEN, T_WLMRD - T_MOD - 1 - SMP_LAT);
    localparam int MAXW     = imax(imax(T_MOD, EN_WAIT),
                                   imax(imax(T_DQSH, T_DQSL), FB_WAIT));
    localparam int CNT_W    = $clog2(MAXW + 1);
    localparam logic [TAP_W-1:0] TAP_TOP = '1;
    localparam logic [CNT_W-1:0] LD_MOD  = CNT_W'(T_MOD - 1);
    localparam logic [CNT_W-1:0] LD_EN   = CNT_W'(EN_WAIT - 1);
    localparam logic [CNT_W-1:0] LD_HI   = CNT_W'(T_DQSH - 1);
    localparam logic [CNT_W-1:0] LD_LO   = CNT_W'(T_DQSL - 1);
    localparam logic [CNT_W-1:0] LD_FB   = CNT_W'(imax(FB_WAIT - 1, 0));

    typedef struct packed {
        wl_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [TAP_W-1:0] tap;
        logic             seen0;
        logic             err;
    } regs_t;

    regs_t q, d;
    logic  fb, stray, active, cnt_zero;

    wrlvl_dq_split #(.DQ_W(DQ_W)) u_split (
        .dq_i    (dq_in),
        .fb_o    (fb),
        .stray_o (stray)
    );

    assign cnt_zero = (q.cnt == '0);
    assign active   = (q.st != ST_IDLE) && (q.st != ST_DONE);

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st    = ST_MRS_ON;
                    d.tap   = '0;
                    d.seen0 = 1'b0;
                    d.err   = 1'b0;
                end
            end
            ST_MRS_ON: begin
                d.st  = ST_MOD;
                d.cnt = LD_MOD;
            end
            ST_MOD: begin
                if (cnt_zero) begin
                    d.st  = ST_ODT;
                    d.cnt = LD_EN;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_ODT: begin
                if (cnt_zero) begin
                    d.st  = ST_HI;
                    d.cnt = LD_HI;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_HI: begin
                if (cnt_zero) begin
                    d.st  = ST_LO;
                    d.cnt = LD_LO;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_LO: begin
                if (cnt_zero) begin
                    d.st  = (FB_WAIT == 0) ? ST_SMP : ST_FBW;
                    d.cnt = LD_FB;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_FBW: begin
                if (cnt_zero) d.st  = ST_SMP;
                else          d.cnt = q.cnt - 1'b1;
            end
            ST_SMP: begin
                if (q.seen0 && fb) begin
                    d.st = ST_ODT_OFF;
                end else if (q.tap == TAP_TOP) begin
                    d.err = 1'b1;
                    d.st  = ST_ODT_OFF;
                end else begin
                    d.tap   = q.tap + 1'b1;
                    d.seen0 = q.seen0 | ~fb;
                    d.st    = ST_HI;
                    d.cnt   = LD_HI;
                end
            end
            ST_ODT_OFF: d.st = ST_MRS_OFF;
            ST_MRS_OFF: d.st = ST_DONE;
            ST_DONE:    d.st = ST_IDLE;
            default:    d.st = ST_IDLE;
        endcase
        if (active && stray) d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, tap: '0, seen0: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        cmd_o    = ((q.st == ST_MRS_ON) || (q.st == ST_MRS_OFF)) ? CMD_MRS : CMD_NOP;
        mr_wl_o  = (q.st == ST_MRS_ON);
        dqs_oe_o = (q.st == ST_HI) || (q.st == ST_LO) || (q.st == ST_FBW) || (q.st == ST_SMP);
        odt_o    = dqs_oe_o || (q.st == ST_ODT);
        dqs_o    = (q.st == ST_HI);
        done_o   = (q.st == ST_DONE);
        tap_o    = q.tap;
        err_o    = q.err;
    end
endmodule

// File: rtl/wrlvl_seq_chk.sv
module wrlvl_seq_chk #(
    parameter int TAP_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cmd_o,
    input logic             mr_wl_o,
    input logic             odt_o,
    input logic             dqs_oe_o,
    input logic             dqs_o,
    input logic [TAP_W-1:0] tap_o,
    input logic             done_o
);
    assert_wl_only_on_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mr_wl_o |-> (cmd_o == 2'b01));

    assert_entry_before_odt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'b01 && mr_wl_o) |=> !odt_o);

    assert_load_then_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 2'b01) |=> (cmd_o == 2'b00));

    assert_load_not_under_odt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        odt_o |-> (cmd_o == 2'b00));

    assert_strobe_under_odt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_oe_o |-> odt_o);

    assert_strobe_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_o |-> dqs_oe_o);

    assert_tap_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_o != $past(tap_o)) |-> (tap_o == $past(tap_o) + 1'b1 || tap_o == '0));

    assert_exit_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(odt_o) |=> (cmd_o == 2'b01 && !mr_wl_o));

    assert_done_after_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(cmd_o) == 2'b01 && !$past(mr_wl_o)));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

bind wrlvl_seq wrlvl_seq_chk #(.TAP_W(TAP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_o    (cmd_o),
    .mr_wl_o  (mr_wl_o),
    .odt_o    (odt_o),
    .dqs_oe_o (dqs_oe_o),
    .dqs_o    (dqs_o),
    .tap_o    (tap_o),
    .done_o   (done_o)
);

// File: tb/wrlvl_seq_tb.sv
module wrlvl_seq_tb;
    localparam int DQ_W = 4;
    localparam int TAP_W = 6;
    // expected timing from the requirements, default parameters
    localparam int P      = (9 > 2) ? 9 : 2;                 // R5
    localparam int PER    = P + 1;
    localparam int ENW    = (25 > 40 - 12 - 1 - P) ? 25 : 40 - 12 - 1 - P; // R4
    localparam int ODT_C  = 1 + 12 + 1;                      // R3
    localparam int DQS_C  = ODT_C + ENW;
    localparam int SMP0_C = DQS_C + P;
    localparam int NV = 6;
    localparam logic [6:0]       V_THR [NV] = '{7'd5, 7'd1, 7'd0, 7'd63, 7'd64, 7'd30};
    localparam logic [TAP_W-1:0] V_TAP [NV] = '{6'd5, 6'd1, 6'd63, 6'd63, 6'd63, 6'd30};
    localparam logic             V_ERR [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [DQ_W-1:1] stray = '0;
    logic [6:0] thr = 7'd0;
    logic fb;
    logic [DQ_W-1:0] dq_in;
    logic [1:0] cmd_o;
    logic mr_wl_o, odt_o, dqs_oe_o, dqs_o, done_o, err_o;
    logic [TAP_W-1:0] tap_o;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int mrs_cnt, mrs1_c, mrs2_c, mrs1_wl, mrs2_wl, bad_cmd;
    int odt_first, odt_last, dqs_first, done_c, done_cnt, tap_at_done, err_at_done;

    assign fb    = ({1'b0, tap_o} >= thr);
    assign dq_in = {stray, fb};

    always #10 clk = ~clk;

    wrlvl_seq #(.DQ_W(DQ_W), .TAP_W(TAP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dq_in(dq_in),
        .cmd_o(cmd_o), .mr_wl_o(mr_wl_o), .odt_o(odt_o), .dqs_oe_o(dqs_oe_o),
        .dqs_o(dqs_o), .tap_o(tap_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
            summary();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run(input logic [6:0] t, input int inj, input int busy_at);
        thr = t;
        mrs_cnt = 0; mrs1_c = 0; mrs2_c = 0; mrs1_wl = 0; mrs2_wl = 0; bad_cmd = 0;
        odt_first = 0; odt_last = 0; dqs_first = 0; done_c = 0; done_cnt = 0;
        tap_at_done = 0; err_at_done = 0;
        @(negedge clk); start = 1'b1;
        for (int n = 1; n <= 900; n++) begin
            @(negedge clk);
            if (cmd_o == 2'b01) begin
                mrs_cnt++;
                if (mrs_cnt == 1) begin mrs1_c = n; mrs1_wl = int'(mr_wl_o); end
                else begin mrs2_c = n; mrs2_wl = int'(mr_wl_o); end
            end else if (cmd_o != 2'b00) bad_cmd++;
            if (odt_o && odt_first == 0) odt_first = n;
            if (odt_o) odt_last = n;
            if (dqs_o && dqs_first == 0) dqs_first = n;
            if (done_o) begin
                done_cnt++;
                if (done_c == 0) begin
                    done_c = n; tap_at_done = int'(tap_o); err_at_done = int'(err_o);
                end
            end
            start = (n == busy_at);
            stray = (n == inj) ? '1 : '0;
            if (done_c != 0 && n >= done_c + 2) break;
        end
        start = 1'b0; stray = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 cmd", int'(cmd_o), 0);
        check("R11 odt", int'(odt_o), 0);
        check("R11 dqs_oe", int'(dqs_oe_o), 0);
        check("R11 dqs", int'(dqs_o), 0);
        check("R11 tap", int'(tap_o), 0);
        check("R11 done/err", int'(done_o) + int'(err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run(V_THR[v], 0, 0);
            check("R1 entry load cycle", mrs1_c, 1);
            check("R1 entry wl bit", mrs1_wl, 1);
            check("R2 load count", mrs_cnt, 2);
            check("R2 nop elsewhere", bad_cmd, 0);
            check("R3 odt rise", odt_first, ODT_C);
            check("R4 first strobe", dqs_first, DQS_C);
            check("R5 R6 done cycle", done_c, SMP0_C + PER * int'(V_TAP[v]) + 3);
            check("R7 R8 tap", tap_at_done, int'(V_TAP[v]));
            check("R7 R8 err", err_at_done, int'(V_ERR[v]));
            check("R10 odt low before exit", odt_last, done_c - 3);
            check("R10 exit load", mrs2_c, done_c - 1);
            check("R10 exit wl bit", mrs2_wl, 0);
            check("R10 done width", done_cnt, 1);
            check("R7 tap held", int'(tap_o), int'(V_TAP[v]));
        end

        // R9 stray high on a non-prime bit, plus R1 start while busy
        run(7'd10, 60, 100);
        check("R9 err set", err_at_done, 1);
        check("R9 lock unaffected", tap_at_done, 10);
        check("R1 busy start ignored", done_c, SMP0_C + PER * 10 + 3);
        check("R1 single run", mrs_cnt, 2);
        repeat (5) @(negedge clk);
        check("R1 no restart", int'(odt_o) + int'(cmd_o), 0);

        // R10 error clears on next start
        run(7'd2, 0, 0);
        check("R10 err cleared", err_at_done, 0);
        check("R7 tap", tap_at_done, 2);

        // R9 stray in idle is ignored
        stray = '1; repeat (3) @(negedge clk);
        check("R9 idle stray ignored", int'(err_o), 0);
        stray = '0;

        summary();
    end
endmodule